// File: doc/BRIEF.md
# Single-Transfer Bus Master for a Classic Wishbone Bus

This block turns one user command at a time into one Wishbone classic (non-pipelined) read or write. The user side offers an address, write data, byte selects and a direction flag through a valid/ready handshake. The bus side raises the cycle line first and the strobe line one clock later. It then holds every outgoing field steady for as many wait states as the slave needs.

A transfer can end in three ways: acknowledge, error or retry. Acknowledge and error finish at once. The cycle and strobe lines fall on the next clock, and a one-cycle done pulse carries a status code. On a read that ends in acknowledge, the read data is also presented. A retry makes the master release the bus for one idle cycle and then issue the same transfer again. When the retry budget is spent, the next retry is reported as exhausted.

A termination seen while the strobe is low is ignored. More than one termination in the same strobed cycle counts as a protocol error. The data width may only be 8, 16, 32 or 64 bits; any other value stops elaboration.

Top module: `bus_xfer_master`

## Requirements
- R1: While reset is held, bus_cycle_o, bus_strobe_o and done_o are 0 and cmd_ready_o is 1.
- R2: bus_strobe_o is only ever 1 together with bus_cycle_o. On every attempt, bus_cycle_o is 1 for exactly one clock with bus_strobe_o at 0 before the strobe rises.
- R3: A command is taken only while cmd_ready_o is 1 (idle). cmd_ready_o is 0 from the clock after acceptance until the done pulse. A cmd_valid_i raised while busy starts no transfer.
- R4: While bus_strobe_o is 1 and no termination has arrived, the outputs bus_addr_o, bus_wdata_o, bus_sel_o and bus_write_o hold their values and match the accepted command. bus_write_o is 1 for a write and 0 for a read.
- R5: bus_ack_i, bus_fail_i and bus_retry_i have no effect while bus_strobe_o is 0.
- R6: On an acknowledge (bus_ack_i alone), cycle and strobe are 0 on the next clock. In that same clock done_o pulses high for one cycle with status_o = 2'b00. For a read, rdata_o then equals the bus_rdata_i value sampled with the acknowledge.
- R7: On an error (bus_fail_i alone), cycle and strobe are 0 on the next clock and done_o pulses with status_o = 2'b01.
- R8: Two or more termination inputs high in the same strobed cycle end the transfer as an error (status_o = 2'b01).
- R9: On a retry (bus_retry_i alone) while the budget lasts, the master holds cycle and strobe at 0 for one clock with no done pulse. It then reissues the same command, starting again with the cycle-only clock.
- R10: After MAX_RETRY reissues, the next retry ends the transfer with status_o = 2'b10 (retries exhausted). MAX_RETRY retries followed by an acknowledge still end in status 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | User command present |
| cmd_ready_o | output | 1 | Master idle, command will be taken |
| cmd_write_i | input | 1 | 1 = write, 0 = read |
| cmd_addr_i | input | ADDR_W | Transfer address |
| cmd_wdata_i | input | DATA_W | Write data |
| cmd_sel_i | input | DATA_W/8 | Byte selects |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 00 ack, 01 error, 10 retries exhausted |
| rdata_o | output | DATA_W | Read data captured on acknowledge |
| bus_cycle_o | output | 1 | Bus cycle in progress |
| bus_strobe_o | output | 1 | Transfer strobe |
| bus_write_o | output | 1 | Write enable |
| bus_addr_o | output | ADDR_W | Bus address |
| bus_wdata_o | output | DATA_W | Bus write data |
| bus_sel_o | output | DATA_W/8 | Bus byte selects |
| bus_rdata_i | input | DATA_W | Slave read data |
| bus_ack_i | input | 1 | Slave acknowledge |
| bus_fail_i | input | 1 | Slave error |
| bus_retry_i | input | 1 | Slave retry request |

## Verification
The properties assume that the slave inputs settle before the rising edge. They also assume the user does not change a command inside the clock it is accepted. The read-capture property assumes an acknowledge that arrives alone.

The slave model in the bench drives the termination lines and read data only on falling edges. It raises a single termination at a time, except in the cases that deliberately test a collision. It inserts 0 to 3 wait states. Stray terminations are injected only in the cycle-only clock, where the strobe is provably low. Commands are driven only on falling edges and are withdrawn once accepted.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_ARM    = 2'd1,
        PH_STROBE = 2'd2,
        PH_GAP    = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        RSP_NONE  = 2'd0,
        RSP_ACK   = 2'd1,
        RSP_FAIL  = 2'd2,
        RSP_RETRY = 2'd3
    } rsp_e;

    localparam logic [1:0] STAT_OK      = 2'b00;
    localparam logic [1:0] STAT_ERR     = 2'b01;
    localparam logic [1:0] STAT_EXHAUST = 2'b10;

endpackage

// File: rtl/xfer_resp_decode.sv
module xfer_resp_decode
    import xfer_pkg::*;
(
    input  logic strobe_i,
    input  logic ack_i,
    input  logic fail_i,
    input  logic retry_i,
    output rsp_e rsp_o
);
    logic collide;

    // two or more terminations together are a protocol error
    assign collide = (ack_i & fail_i) | (ack_i & retry_i) | (fail_i & retry_i);

    always_comb begin
        rsp_o = RSP_NONE;
        if (strobe_i) begin
            if (collide)      rsp_o = RSP_FAIL;
            else if (ack_i)   rsp_o = RSP_ACK;
            else if (fail_i)  rsp_o = RSP_FAIL;
            else if (retry_i) rsp_o = RSP_RETRY;
        end
    end
endmodule

// File: rtl/xfer_retry_ctr.sv
module xfer_retry_ctr #(
    parameter int MAX_RETRY = 3,
    localparam int CNT_W    = (MAX_RETRY < 1) ? 1 : $clog2(MAX_RETRY + 1)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic incr_i,
    output logic at_limit_o
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_RETRY);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i)                    cnt_d = '0;
        else if (incr_i && !at_limit_o) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign at_limit_o = (cnt_q == LIMIT);
endmodule

// File: rtl/bus_xfer_master.sv
module bus_xfer_master
    import xfer_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int MAX_RETRY = 3,
    localparam int SEL_W    = DATA_W / 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cmd_valid_i,
    output logic              cmd_ready_o,
    input  logic              cmd_write_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic [DATA_W-1:0] cmd_wdata_i,
    input  logic [SEL_W-1:0]  cmd_sel_i,
    output logic              done_o,
    output logic [1:0]        status_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              bus_cycle_o,
    output logic              bus_strobe_o,
    output logic              bus_write_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    output logic [SEL_W-1:0]  bus_sel_o,
    input  logic [DATA_W-1:0] bus_rdata_i,
    input  logic              bus_ack_i,
    input  logic              bus_fail_i,
    input  logic              bus_retry_i
);
    if (!(DATA_W == 8 || DATA_W == 16 || DATA_W == 32 || DATA_W == 64)) begin : g_bad_width
        $error("bus_xfer_master: DATA_W must be 8, 16, 32 or 64");
    end

    typedef struct packed {
        phase_e              phase;
        logic                wr;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic [SEL_W-1:0]    sel;
        logic                done;
        logic [1:0]          status;
        logic [DATA_W-1:0]   rdata;
    } regs_t;

    regs_t r_d, r_q;
    rsp_e  rsp;
    logic  retry_clr, retry_inc, retry_at_limit;

    xfer_resp_decode u_dec (
        .strobe_i (r_q.phase == PH_STROBE),
        .ack_i    (bus_ack_i),
        .fail_i   (bus_fail_i),
        .retry_i  (bus_retry_i),
        .rsp_o    (rsp)
    );

    xfer_retry_ctr #(.MAX_RETRY(MAX_RETRY)) u_retry (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clear_i    (retry_clr),
        .incr_i     (retry_inc),
        .at_limit_o (retry_at_limit)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        retry_clr = 1'b0;
        retry_inc = 1'b0;
        unique case (r_q.phase)
            PH_IDLE: begin
                if (cmd_valid_i) begin
                    r_d.phase = PH_ARM;
                    r_d.wr    = cmd_write_i;
                    r_d.addr  = cmd_addr_i;
                    r_d.wdata = cmd_wdata_i;
                    r_d.sel   = cmd_sel_i;
                    retry_clr = 1'b1;
                end
            end
            PH_ARM: r_d.phase = PH_STROBE;
            PH_STROBE: begin
                unique case (rsp)
                    RSP_ACK: begin
                        r_d.phase  = PH_IDLE;
                        r_d.done   = 1'b1;
                        r_d.status = STAT_OK;
                        if (!r_q.wr) r_d.rdata = bus_rdata_i;
                    end
                    RSP_FAIL: begin
                        r_d.phase  = PH_IDLE;
                        r_d.done   = 1'b1;
                        r_d.status = STAT_ERR;
                    end
                    RSP_RETRY: begin
                        if (retry_at_limit) begin
                            r_d.phase  = PH_IDLE;
                            r_d.done   = 1'b1;
                            r_d.status = STAT_EXHAUST;
                        end else begin
                            r_d.phase = PH_GAP;
                            retry_inc = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
            PH_GAP: r_d.phase = PH_ARM;
            default: r_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign cmd_ready_o  = (r_q.phase == PH_IDLE);
    assign bus_cycle_o  = (r_q.phase == PH_ARM) || (r_q.phase == PH_STROBE);
    assign bus_strobe_o = (r_q.phase == PH_STROBE);
    assign bus_write_o  = r_q.wr;
    assign bus_addr_o   = r_q.addr;
    assign bus_wdata_o  = r_q.wdata;
    assign bus_sel_o    = r_q.sel;
    assign done_o       = r_q.done;
    assign status_o     = r_q.status;
    assign rdata_o      = r_q.rdata;
endmodule

// File: rtl/xfer_master_chk.sv
module xfer_master_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int SEL_W = DATA_W / 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              cmd_ready_o,
    input logic              done_o,
    input logic [1:0]        status_o,
    input logic [DATA_W-1:0] rdata_o,
    input logic              bus_cycle_o,
    input logic              bus_strobe_o,
    input logic              bus_write_o,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic [DATA_W-1:0] bus_wdata_o,
    input logic [SEL_W-1:0]  bus_sel_o,
    input logic [DATA_W-1:0] bus_rdata_i,
    input logic              bus_ack_i,
    input logic              bus_fail_i,
    input logic              bus_retry_i
);
    logic any_term;
    assign any_term = bus_ack_i | bus_fail_i | bus_retry_i;

    always_comb begin
        if (!rst_ni) begin
            AST_RESET_QUIET: assert (!bus_cycle_o && !bus_strobe_o && !done_o); // R1
        end
    end

    AST_STROBE_IN_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_strobe_o |-> bus_cycle_o); // R2

    AST_CYCLE_LEADS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(bus_strobe_o) |-> $past(bus_cycle_o)); // R2

    AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_cycle_o |-> !cmd_ready_o); // R3

    AST_HOLD_WHILE_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_strobe_o && !any_term |=>
            $stable(bus_addr_o) && $stable(bus_wdata_o) && $stable(bus_sel_o) && $stable(bus_write_o)); // R4

    AST_END_AFTER_FINAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_strobe_o && (bus_ack_i || bus_fail_i) |=> done_o && !bus_cycle_o && !bus_strobe_o); // R7

    AST_READ_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_strobe_o && bus_ack_i && !bus_fail_i && !bus_retry_i && !bus_write_o |=>
            done_o && status_o == 2'b00 && rdata_o == $past(bus_rdata_i)); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R6

    AST_RETRY_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_strobe_o && bus_retry_i |=> !bus_cycle_o && !bus_strobe_o); // R9

    AST_STATUS_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> status_o != 2'b11); // R10
endmodule

bind bus_xfer_master xfer_master_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_ready_o  (cmd_ready_o),
    .done_o       (done_o),
    .status_o     (status_o),
    .rdata_o      (rdata_o),
    .bus_cycle_o  (bus_cycle_o),
    .bus_strobe_o (bus_strobe_o),
    .bus_write_o  (bus_write_o),
    .bus_addr_o   (bus_addr_o),
    .bus_wdata_o  (bus_wdata_o),
    .bus_sel_o    (bus_sel_o),
    .bus_rdata_i  (bus_rdata_i),
    .bus_ack_i    (bus_ack_i),
    .bus_fail_i   (bus_fail_i),
    .bus_retry_i  (bus_retry_i)
);

// File: tb/sim_bus_xfer_master.sv
`timescale 1ns/1ps
module sim_bus_xfer_master;
    localparam int ADDR_W    = 32;
    localparam int DATA_W    = 32;
    localparam int MAX_RETRY = 3;
    localparam int SEL_W     = DATA_W / 8;

    // final responses: 0 ack, 1 error, 2 collision (ack+error)
    localparam int FIN_ACK = 0, FIN_ERR = 1, FIN_MULTI = 2;

    logic clk = 1'b0;
    logic rst_ni = 1'b1;
    logic cmd_valid = 1'b0, cmd_write = 1'b0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [DATA_W-1:0] cmd_wdata = '0;
    logic [SEL_W-1:0]  cmd_sel = '0;
    logic [DATA_W-1:0] s_rdata = '0;
    logic s_ack = 1'b0, s_fail = 1'b0, s_retry = 1'b0;

    logic cmd_ready, done, cyc, stb, we;
    logic [1:0] status;
    logic [DATA_W-1:0] rdata, wdata_o;
    logic [ADDR_W-1:0] addr_o;
    logic [SEL_W-1:0]  sel_o;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    bus_xfer_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_RETRY(MAX_RETRY)) u0 (
        .clk_i(clk), .rst_ni(rst_ni),
        .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_write_i(cmd_write),
        .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata), .cmd_sel_i(cmd_sel),
        .done_o(done), .status_o(status), .rdata_o(rdata),
        .bus_cycle_o(cyc), .bus_strobe_o(stb), .bus_write_o(we),
        .bus_addr_o(addr_o), .bus_wdata_o(wdata_o), .bus_sel_o(sel_o),
        .bus_rdata_i(s_rdata), .bus_ack_i(s_ack), .bus_fail_i(s_fail), .bus_retry_i(s_retry)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] exp_status(input int n_rty, input int fin);
        if (n_rty > MAX_RETRY) return 2'b10;
        if (fin == FIN_ACK)    return 2'b00;
        return 2'b01;
    endfunction

    task automatic check_fields(input bit w, input logic [ADDR_W-1:0] a,
                                input logic [DATA_W-1:0] d, input logic [SEL_W-1:0] s);
        check(addr_o == a, "R4 addr", 64'(addr_o), 64'(a));
        check(wdata_o == d && sel_o == s, "R4 data/sel", 64'({sel_o, wdata_o}), 64'({s, d}));
        check(we == w, "R4 write flag", 64'(we), 64'(w));
    endtask

    task automatic xfer(input bit w, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                        input logic [SEL_W-1:0] s, input int n_rty, input int fin,
                        input int waits, input bit spur, input bit busy_cmd);
        logic [DATA_W-1:0] rd_exp = '0;
        bit ended = 1'b0;
        @(negedge clk);
        check(cmd_ready == 1'b1, "R3 ready when idle", 64'(cmd_ready), 64'd1);
        cmd_valid = 1'b1; cmd_write = w; cmd_addr = a; cmd_wdata = d; cmd_sel = s;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_addr = ~a;
        for (int att = 0; !ended; att++) begin
            // cycle-only clock
            check(cyc == 1'b1 && stb == 1'b0, "R2 cycle before strobe", 64'({cyc, stb}), 64'b10);
            check(cmd_ready == 1'b0, "R3 busy", 64'(cmd_ready), 64'd0);
            if (spur && att == 0) begin s_ack = 1'b1; s_retry = 1'b1; end
            if (busy_cmd && att == 0) cmd_valid = 1'b1;
            @(negedge clk);
            s_ack = 1'b0; s_retry = 1'b0; cmd_valid = 1'b0;
            check(stb == 1'b1 && done == 1'b0, "R5 stray term ignored, strobe up", 64'({stb, done}), 64'b10);
            check_fields(w, a, d, s);
            for (int k = 0; k < waits; k++) begin
                @(negedge clk);
                check(stb == 1'b1, "R4 wait state", 64'(stb), 64'd1);
                check_fields(w, a, d, s);
            end
            s_rdata = DATA_W'($urandom);
            if (att < n_rty) s_retry = 1'b1;
            else if (fin == FIN_ACK) s_ack = 1'b1;
            else if (fin == FIN_ERR) s_fail = 1'b1;
            else begin s_ack = 1'b1; s_fail = 1'b1; end
            rd_exp = s_rdata;
            @(negedge clk);
            s_ack = 1'b0; s_fail = 1'b0; s_retry = 1'b0;
            s_rdata = ~rd_exp;
            check(cyc == 1'b0 && stb == 1'b0, "R6 bus released", 64'({cyc, stb}), 64'd0);
            if (att < n_rty && att < MAX_RETRY) begin
                check(done == 1'b0, "R9 no done on retry", 64'(done), 64'd0);
                @(negedge clk);
            end else begin
                check(done == 1'b1, "R6 done pulse", 64'(done), 64'd1);
                check(status == exp_status(n_rty, fin), "R7 R8 R10 status",
                      64'(status), 64'(exp_status(n_rty, fin)));
                if (!w && n_rty <= MAX_RETRY && fin == FIN_ACK)
                    check(rdata == rd_exp, "R6 read data", 64'(rdata), 64'(rd_exp));
                @(negedge clk);
                check(done == 1'b0 && cyc == 1'b0, "R3 no extra transfer, done single",
                      64'({done, cyc}), 64'd0);
                ended = 1'b1;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        #1 rst_ni = 1'b0;
        repeat (3) @(negedge clk);
        check(cyc == 1'b0 && stb == 1'b0 && done == 1'b0, "R1 reset quiet",
              64'({cyc, stb, done}), 64'd0);
        check(cmd_ready == 1'b1, "R1 ready in reset", 64'(cmd_ready), 64'd1);
        rst_ni = 1'b1;
        // directed corners
        xfer(1'b0, 32'h0000_1000, 32'h0,         4'hF, 0, FIN_ACK,   0, 0, 0); // R6 read
        xfer(1'b1, 32'h0000_2004, 32'hDEAD_BEEF, 4'h3, 0, FIN_ACK,   2, 0, 0); // R4 write
        xfer(1'b1, 32'h0000_3008, 32'h1234_5678, 4'hC, 0, FIN_ERR,   1, 0, 0); // R7
        xfer(1'b0, 32'h0000_400C, 32'h0,         4'h1, 0, FIN_ERR,   0, 0, 0); // R7
        xfer(1'b0, 32'h0000_5010, 32'h0,         4'hF, 0, FIN_MULTI, 0, 0, 0); // R8
        xfer(1'b0, 32'h0000_6014, 32'h0,         4'hF, 1, FIN_ACK,   1, 0, 0); // R9
        xfer(1'b1, 32'h0000_7018, 32'hA5A5_5A5A, 4'hF, MAX_RETRY, FIN_ACK, 0, 0, 0); // R10 boundary
        xfer(1'b0, 32'h0000_801C, 32'h0,         4'hF, MAX_RETRY + 1, FIN_ACK, 1, 0, 0); // R10 exhausted
        xfer(1'b0, 32'h0000_9020, 32'h0,         4'hF, 0, FIN_ACK,   0, 1, 0); // R5 stray
        xfer(1'b1, 32'h0000_A024, 32'h0BAD_F00D, 4'h6, 0, FIN_ACK,   1, 0, 1); // R3 busy cmd
        // constrained random
        for (int i = 0; i < 60; i++) begin
            xfer(1'($urandom), ADDR_W'($urandom), DATA_W'($urandom), SEL_W'($urandom),
                 int'($urandom_range(0, MAX_RETRY + 1)), int'($urandom_range(0, 2)),
                 int'($urandom_range(0, 3)), 1'($urandom), 1'($urandom));
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule